// File: doc/BRIEF.md
# Erase-Block Write-Protection Lock Manager

This block keeps a write-protection state for every erase block of a flash array. Each block is unlocked, locked, or lock-tight. Commands act on a range of blocks: unlock a range, lock a range, move a range to lock-tight, or unlock the whole array. Two range registers define the range. A write to the start register also loads the same value into the end register, so a single-block command needs only one register write.

When a command is accepted, the manager walks the range one block per clock. It writes each block's new state into the array and copies that state into a write-protection status output. A lock-tight block ends an unlock or lock walk. The lock-tight command leaves unlocked blocks alone. A block index at or beyond the block count ends the walk with a command error. At the end of every command the manager raises done for one cycle.

A query port reads the current state of any block. Whatever checks program and erase permission uses this port.

Top module: `blk_wlock_mgr`

## Requirements
- R1: After a synchronous reset every block reads locked, wp_status is 3'b010, start_blk and end_blk are 0, and busy, done and cmd_err are 0.
- R2: States are one-hot: lock-tight = 3'b001, locked = 3'b010, unlocked = 3'b100. The cmd_op codes are 0 = unlock range, 1 = lock range, 2 = lock-tight range, 3 = unlock all.
- R3: A start write stores the low ADDR_W bits of addr_wdata into both start_blk and end_blk. An end write stores them into end_blk only. Both registers change on the clock after the strobe.
- R4: Unlock and lock walk from start_blk to end_blk inclusive, one block per clock. With a walk of n visited blocks accepted at edge 0, done is high after edge n.
- R5: An unlock, lock or unlock-all walk that reaches a lock-tight block ends there. That block and every block after it keep their state. The stopping block counts as a visited cycle.
- R6: Lock-tight moves every locked or lock-tight block of the range to lock-tight and leaves unlocked blocks unchanged.
- R7: Reaching a block index at or above NUM_BLOCKS sets cmd_err and ends the walk. Blocks before that index are still processed. cmd_err clears when the next command is accepted.
- R8: wp_status holds the new state of the last block written. A command that writes no block leaves it unchanged.
- R9: Unlock-all walks from block 0 to NUM_BLOCKS-1 and ignores the range registers.
- R10: If start_blk is greater than end_blk for an unlock, lock or lock-tight command, no block changes and done is high after the accepting edge.
- R11: A command presented while busy is ignored.
- R12: done lasts exactly one cycle and never coincides with busy. busy is high from the accepting edge until the edge that raises done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_wdata | input | DATA_W | Write data for the range registers |
| start_we | input | 1 | Write strobe for the start register (also loads end) |
| end_we | input | 1 | Write strobe for the end register |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | Command code |
| query_idx | input | ADDR_W | Block index to read |
| query_state | output | 3 | One-hot state of the queried block |
| start_blk | output | ADDR_W | Start register |
| end_blk | output | ADDR_W | End register |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Last command hit an out-of-range block |
| wp_status | output | 3 | State of the last block written |

## Verification
The out-of-range error can only be reached when the block count is not a power of two. The default of twelve blocks with four-bit indices lets the exhaustive sweep over every start/end pair run past the array. The stop at a lock-tight block in the middle of a walk requires the array to be shaped first. The stimulus unlocks part of the array, tightens a range that spans both locked and unlocked blocks, and then walks into it from either side. A second request is injected while a long walk is still running, and the final array is compared with a model that applies only the first command.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

    typedef enum logic [2:0] {
        WP_TIGHT    = 3'b001,
        WP_LOCKED   = 3'b010,
        WP_UNLOCKED = 3'b100
    } wp_state_e;

    typedef enum logic [1:0] {
        OP_UNLOCK     = 2'd0,
        OP_LOCK       = 2'd1,
        OP_TIGHTEN    = 2'd2,
        OP_UNLOCK_ALL = 2'd3
    } wp_op_e;

    typedef enum logic {
        W_IDLE = 1'b0,
        W_RUN  = 1'b1
    } walk_fsm_e;

    // Outcome of visiting one block during a walk
    typedef struct packed {
        logic      write;
        logic      finish;
        logic      err;
        wp_state_e nstate;
    } step_t;

    function automatic step_t decide_step(wp_op_e op, wp_state_e cur,
                                          logic oor, logic at_last);
        step_t d;
        d.write  = 1'b0;
        d.finish = 1'b0;
        d.err    = 1'b0;
        d.nstate = WP_LOCKED;
        if (oor) begin
            d.err    = 1'b1;
            d.finish = 1'b1;
        end else if (op == OP_TIGHTEN) begin
            if (cur != WP_UNLOCKED) begin
                d.write  = 1'b1;
                d.nstate = WP_TIGHT;
            end
            d.finish = at_last;
        end else if (cur == WP_TIGHT) begin
            d.finish = 1'b1;
        end else begin
            d.write  = 1'b1;
            d.nstate = (op == OP_LOCK) ? WP_LOCKED : WP_UNLOCKED;
            d.finish = at_last;
        end
        return d;
    endfunction

endpackage

// File: rtl/wlock_range_regs.sv
module wlock_range_regs #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] addr_wdata,
    input  logic              start_we,
    input  logic              end_we,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q
);
    logic [ADDR_W-1:0] masked;
    assign masked = addr_wdata[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            end_q   <= '0;
        end else begin
            if (start_we) begin
                start_q <= masked;
                end_q   <= masked;
            end
            if (end_we) begin
                end_q <= masked;
            end
        end
    end
endmodule

// File: rtl/wlock_state_array.sv
module wlock_state_array
    import wlock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  wp_state_e         wr_state,
    input  logic [ADDR_W-1:0] rd_idx,
    output wp_state_e         rd_state,
    input  logic [ADDR_W-1:0] q_idx,
    output wp_state_e         q_state
);
    localparam logic [ADDR_W:0] NUM_L = (ADDR_W+1)'(NUM_BLOCKS);

    wp_state_e st [NUM_BLOCKS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (rst) begin
                st[i] <= WP_LOCKED;
            end else if (wr_en && wr_idx == ADDR_W'(i)) begin
                st[i] <= wr_state;
            end
        end
    end

    // Two read ports share one guarded mux structure
    logic [ADDR_W-1:0] rd_addr [2];
    wp_state_e         rd_data [2];
    assign rd_addr[0] = rd_idx;
    assign rd_addr[1] = q_idx;

    for (genvar p = 0; p < 2; p++) begin : g_rport
        always_comb begin
            rd_data[p] = WP_LOCKED;
            for (int i = 0; i < NUM_BLOCKS; i++) begin
                if (rd_addr[p] == ADDR_W'(i)) rd_data[p] = st[i];
            end
            if ({1'b0, rd_addr[p]} >= NUM_L) rd_data[p] = WP_LOCKED;
        end
    end

    assign rd_state = rd_data[0];
    assign q_state  = rd_data[1];
endmodule

// File: rtl/wlock_walker.sv
module wlock_walker
    import wlock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  wp_op_e            cmd_op,
    input  logic [ADDR_W-1:0] start_blk,
    input  logic [ADDR_W-1:0] end_blk,
    input  wp_state_e         rd_state,
    output logic [ADDR_W-1:0] cur_idx,
    output logic              wr_en,
    output wp_state_e         wr_state,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output wp_state_e         wp_status
);
    localparam logic [ADDR_W:0]   NUM_L   = (ADDR_W+1)'(NUM_BLOCKS);
    localparam logic [ADDR_W-1:0] LAST_IX = ADDR_W'(NUM_BLOCKS - 1);

    walk_fsm_e         fsm_q;
    wp_op_e            op_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] last_q;
    step_t             step;
    logic              oor;

    assign oor  = ({1'b0, cur_q} >= NUM_L);
    assign step = decide_step(op_q, rd_state, oor, cur_q == last_q);

    assign cur_idx  = cur_q;
    assign busy     = (fsm_q == W_RUN);
    assign wr_en    = busy && step.write;
    assign wr_state = step.nstate;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q     <= W_IDLE;
            op_q      <= OP_UNLOCK;
            cur_q     <= '0;
            last_q    <= '0;
            done      <= 1'b0;
            cmd_err   <= 1'b0;
            wp_status <= WP_LOCKED;
        end else begin
            done <= 1'b0;
            case (fsm_q)
                W_IDLE: begin
                    if (cmd_valid) begin
                        cmd_err <= 1'b0;
                        op_q    <= cmd_op;
                        if (cmd_op == OP_UNLOCK_ALL) begin
                            cur_q  <= '0;
                            last_q <= LAST_IX;
                            fsm_q  <= W_RUN;
                        end else if (start_blk > end_blk) begin
                            done <= 1'b1;
                        end else begin
                            cur_q  <= start_blk;
                            last_q <= end_blk;
                            fsm_q  <= W_RUN;
                        end
                    end
                end
                W_RUN: begin
                    if (step.write) wp_status <= step.nstate;
                    if (step.err)   cmd_err   <= 1'b1;
                    if (step.finish) begin
                        fsm_q <= W_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cur_q <= cur_q + 1'b1;
                    end
                end
                default: fsm_q <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blk_wlock_mgr.sv
module blk_wlock_mgr
    import wlock_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] addr_wdata,
    input  logic              start_we,
    input  logic              end_we,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] query_idx,
    output logic [2:0]        query_state,
    output logic [ADDR_W-1:0] start_blk,
    output logic [ADDR_W-1:0] end_blk,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output logic [2:0]        wp_status
);
    logic [ADDR_W-1:0] cur_idx;
    logic              wr_en;
    wp_state_e         wr_state;
    wp_state_e         rd_state;
    wp_state_e         q_state;
    wp_state_e         status_e;

    wlock_range_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr_wdata (addr_wdata),
        .start_we   (start_we),
        .end_we     (end_we),
        .start_q    (start_blk),
        .end_q      (end_blk)
    );

    wlock_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (cur_idx),
        .wr_state (wr_state),
        .rd_idx   (cur_idx),
        .rd_state (rd_state),
        .q_idx    (query_idx),
        .q_state  (q_state)
    );

    wlock_walker #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (wp_op_e'(cmd_op)),
        .start_blk (start_blk),
        .end_blk   (end_blk),
        .rd_state  (rd_state),
        .cur_idx   (cur_idx),
        .wr_en     (wr_en),
        .wr_state  (wr_state),
        .busy      (busy),
        .done      (done),
        .cmd_err   (cmd_err),
        .wp_status (status_e)
    );

    assign query_state = q_state;
    assign wp_status   = status_e;
endmodule

// File: rtl/blk_wlock_mgr_chk.sv
module blk_wlock_mgr_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] addr_wdata,
    input logic              start_we,
    input logic              end_we,
    input logic [ADDR_W-1:0] start_blk,
    input logic [ADDR_W-1:0] end_blk,
    input logic              busy,
    input logic              done,
    input logic              cmd_err,
    input logic [2:0]        wp_status,
    input logic              wr_en
);
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_write_in_walk_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    assert_status_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(wp_status) == 1);

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_err) |-> done);

    assert_start_copy_R3: assert property (@(posedge clk) disable iff (rst)
        (start_we && !end_we) |=>
            (start_blk == $past(addr_wdata[ADDR_W-1:0]) &&
             end_blk   == $past(addr_wdata[ADDR_W-1:0])));
endmodule

bind blk_wlock_mgr blk_wlock_mgr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_wdata (addr_wdata),
    .start_we   (start_we),
    .end_we     (end_we),
    .start_blk  (start_blk),
    .end_blk    (end_blk),
    .busy       (busy),
    .done       (done),
    .cmd_err    (cmd_err),
    .wp_status  (wp_status),
    .wr_en      (wr_en)
);

// File: tb/test_blk_wlock_mgr.sv
module test_blk_wlock_mgr;
    localparam int N  = 12;
    localparam int DW = 16;
    localparam int AW = 4;

    localparam int S_TIGHT = 1, S_LOCKED = 2, S_UNLOCKED = 4;
    localparam int C_UNLOCK = 0, C_LOCK = 1, C_TIGHT = 2, C_ALL = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] addr_wdata = '0;
    logic          start_we = 1'b0, end_we = 1'b0, cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [AW-1:0] query_idx = '0;
    logic [2:0]    query_state, wp_status;
    logic [AW-1:0] start_blk, end_blk;
    logic          busy, done, cmd_err;

    int checks = 0, errors = 0;
    int mdl [N];
    int m_status;

    always #10 clk = ~clk;

    blk_wlock_mgr #(.NUM_BLOCKS(N), .DATA_W(DW)) i_blk_wlock_mgr (
        .clk(clk), .rst(rst), .addr_wdata(addr_wdata), .start_we(start_we),
        .end_we(end_we), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .query_idx(query_idx), .query_state(query_state),
        .start_blk(start_blk), .end_blk(end_blk), .busy(busy), .done(done),
        .cmd_err(cmd_err), .wp_status(wp_status)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sweep(string req);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        for (int b = 0; b < N; b++) begin
            query_idx = AW'(b);
            #1;
            if (int'(query_state) != mdl[b]) begin
                if (bad == 0) begin
                    first_act = int'(query_state);
                    first_exp = mdl[b];
                end
                bad++;
            end
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < N; b++) mdl[b] = S_LOCKED;
        m_status = S_LOCKED;
    endtask

    // Reference walk built from the requirements
    task automatic model_run(int op, int s, int e, output int steps, output bit err);
        steps = 0;
        err = 1'b0;
        if (op == C_ALL) begin
            s = 0;
            e = N - 1;
        end
        for (int b = s; b <= e; b++) begin
            steps++;
            if (b >= N) begin
                err = 1'b1;
                break;
            end
            if (op == C_TIGHT) begin
                if (mdl[b] != S_UNLOCKED) begin
                    mdl[b] = S_TIGHT;
                    m_status = S_TIGHT;
                end
            end else begin
                if (mdl[b] == S_TIGHT) break;
                mdl[b] = (op == C_LOCK) ? S_LOCKED : S_UNLOCKED;
                m_status = mdl[b];
            end
        end
    endtask

    task automatic issue(int op, int s, int e, bit set_end, bit interfere, string req);
        int exp_steps, k;
        bit exp_err;
        int ee;
        @(negedge clk);
        addr_wdata = DW'(16'h5a30 | s);
        start_we = 1'b1;
        @(negedge clk);
        start_we = 1'b0;
        ee = s;
        if (set_end) begin
            addr_wdata = DW'(16'hc6d0 | e);
            end_we = 1'b1;
            ee = e;
            @(negedge clk);
            end_we = 1'b0;
        end
        model_run(op, s, ee, exp_steps, exp_err);
        cmd_op = 2'(op);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        k = 0;
        while (!done && k < 100) begin
            if (interfere && k == 1) begin
                cmd_valid = 1'b1;
                cmd_op = 2'(C_TIGHT);
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        cmd_valid = 1'b0;
        chk(k == exp_steps, "R4 R10 walk length", k, exp_steps);
        chk(cmd_err == exp_err, "R7 cmd_err", int'(cmd_err), int'(exp_err));
        chk(int'(wp_status) == m_status, "R8 wp_status", int'(wp_status), m_status);
        sweep(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(int'(wp_status) == S_LOCKED, "R1 wp_status", int'(wp_status), S_LOCKED);
        chk(start_blk == 0 && end_blk == 0, "R1 range regs", int'(start_blk), 0);
        chk(!busy && !done && !cmd_err, "R1 flags", int'({busy, done, cmd_err}), 0);
        sweep("R1 R2 all blocks locked");

        // R3: masking and copy into end register
        @(negedge clk);
        addr_wdata = 16'hfff7;
        start_we = 1'b1;
        @(negedge clk);
        start_we = 1'b0;
        chk(start_blk == 7 && end_blk == 7, "R3 start copies to end",
            int'(end_blk), 7);
        addr_wdata = 16'h1239;
        end_we = 1'b1;
        @(negedge clk);
        end_we = 1'b0;
        chk(start_blk == 7 && end_blk == 9, "R3 end write only",
            int'({start_blk, end_blk}), 16'h79);

        // R4 R7 R8 R10: exhaustive start/end sweep with unlock and lock
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                issue(((s + e) % 2 == 1) ? C_LOCK : C_UNLOCK, s, e, 1'b1, 1'b0,
                      "R4 R7 R10 range sweep");
            end
        end

        // R5 R6: lock-tight shaping and stopping
        do_reset();
        issue(C_UNLOCK, 2, 9, 1'b1, 1'b0, "R4 unlock 2..9");
        issue(C_TIGHT, 0, 5, 1'b1, 1'b0, "R6 tighten skips unlocked");
        issue(C_TIGHT, 6, 7, 1'b1, 1'b0, "R6 R8 tighten only unlocked");
        issue(C_UNLOCK, 0, 3, 1'b1, 1'b0, "R5 unlock stops at tight");
        issue(C_ALL, 0, 0, 1'b0, 1'b0, "R5 R9 unlock-all stops at block 0");
        issue(C_TIGHT, 10, 14, 1'b1, 1'b0, "R6 R7 tighten past end");

        do_reset();
        issue(C_TIGHT, 5, 0, 1'b0, 1'b0, "R3 R6 single-block tighten");
        issue(C_ALL, 0, 0, 1'b0, 1'b0, "R9 unlock-all stops at block 5");
        issue(C_LOCK, 3, 8, 1'b1, 1'b0, "R5 lock stops at block 5");

        // R11: request while busy
        do_reset();
        issue(C_UNLOCK, 0, 11, 1'b1, 1'b1, "R11 busy command ignored");

        // R9: clean unlock-all
        do_reset();
        issue(C_ALL, 9, 2, 1'b1, 1'b0, "R9 unlock-all ignores range");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule